// File: doc/BRIEF.md
# Seek Address Tracking and Mode Logic

This block keeps track of a disk head positioner during a seek. It holds the target cylinder in a demand register and the head's present cylinder in a counter that moves by one on each track-crossing pulse. The counter moves up or down according to a direction input. From these two values it derives the remaining distance, a zero flag and a direction flag. It also drives the two mode outputs that steer the servo. The velocity-reference enable is active while the head still has cylinders to travel. The position-mode output is active once the head has arrived and is within a quarter track of the track centre.

Either slow-mode flag raises a clear condition. This condition is used during initialization, head load or retract, and restore. While it lasts, the counter is preset to all ones, load and count pulses are ignored, and both mode outputs are held off. Tracking resumes only when both flags are low. The address width is a parameter with a default of 9 bits. All state resets synchronously.

Top module: `seek_addr_track`

## Requirements
- R1: While `rst` is high at a clock edge, the demand register is set to zero and the current counter is set to all ones.
- R2: At a clock edge where either `fwd_slow` or `rev_slow` is high, the current counter is set to all ones.
- R3: While either slow flag is high, `vel_ref_en` and `pos_mode` are both low in the same cycle, whatever the address values are.
- R4: While either slow flag is high, `load_pulse` and `xing_pulse` have no effect. The demand register keeps its value.
- R5: At a clock edge where both slow flags are low and `load_pulse` is high, the demand register takes the value on `addr_in`.
- R6: At a clock edge where both slow flags are low and `xing_pulse` is high, the current counter adds one if `dir_fwd` is 1 and subtracts one if it is 0. It wraps modulo 2^W.
- R7: `diff` equals (demand − current) modulo 2^W. `diff_zero` is 1 exactly when the two values are equal.
- R8: `move_fwd` is 1 exactly when demand is greater than current, compared as unsigned values.
- R9: `vel_ref_en` is 1 exactly when both slow flags are low and `diff` is nonzero.
- R10: `pos_mode` is 1 exactly when both slow flags are low, `diff` is zero and `quad_clk` is low.
- R11: A load and a count pulse in the same released cycle both take effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fwd_slow | input | 1 | Forward slow-mode flag |
| rev_slow | input | 1 | Reverse slow-mode flag |
| load_pulse | input | 1 | Load target from addr_in |
| addr_in | input | W | Target cylinder address |
| xing_pulse | input | 1 | Track-crossing count pulse, one cycle per crossing |
| dir_fwd | input | 1 | Count direction, 1 = up |
| quad_clk | input | 1 | Quarter-track position quadrature clock |
| demand_addr | output | W | Demand register |
| current_addr | output | W | Current counter |
| diff | output | W | Demand minus current, modulo 2^W |
| diff_zero | output | 1 | Demand equals current |
| move_fwd | output | 1 | Demand above current |
| vel_ref_en | output | 1 | Velocity reference enable |
| pos_mode | output | 1 | Position mode |

## Verification
Register effects follow one cycle after a stimulus. A load, a count pulse, a clear or a reset shows on `demand_addr` and `current_addr` after the next rising edge. `diff`, `diff_zero`, `move_fwd` and the two mode outputs are combinational in the same cycle, from the registers and the present flags and `quad_clk`. The bench drives inputs on the falling edge and compares every output shortly after. A behavioural model advances on the rising edge, so each register result is checked in the cycle after its cause and each combinational result in the cycle of its cause.

// File: rtl/seek_addr_track.sv
module seek_addr_track #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fwd_slow,
  input  logic         rev_slow,
  input  logic         load_pulse,
  input  logic [W-1:0] addr_in,
  input  logic         xing_pulse,
  input  logic         dir_fwd,
  input  logic         quad_clk,
  output logic [W-1:0] demand_addr,
  output logic [W-1:0] current_addr,
  output logic [W-1:0] diff,
  output logic         diff_zero,
  output logic         move_fwd,
  output logic         vel_ref_en,
  output logic         pos_mode
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic clr;
  assign clr = fwd_slow | rev_slow;

  always_ff @(posedge clk) begin
    if (rst) begin
      demand_addr <= '0;
    end else if (!clr && load_pulse) begin
      demand_addr <= addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      current_addr <= ALL_ONES;
    end else if (xing_pulse) begin
      current_addr <= dir_fwd ? current_addr + 1'b1 : current_addr - 1'b1;
    end
  end

  assign diff       = demand_addr - current_addr;
  assign diff_zero  = (diff == '0);
  assign move_fwd   = demand_addr > current_addr;
  assign vel_ref_en = !clr && !diff_zero;
  assign pos_mode   = !clr && diff_zero && !quad_clk;

  AST_CLR_PRESET: assert property (@(posedge clk) disable iff (rst)
    clr |=> current_addr == ALL_ONES); // R2
  AST_CLR_HOLD: assert property (@(posedge clk) disable iff (rst)
    clr |=> demand_addr == $past(demand_addr)); // R4
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_pulse) |=> demand_addr == $past(addr_in)); // R5
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
    (!clr && xing_pulse && dir_fwd) |=> current_addr == $past(current_addr) + 1'b1); // R6
  AST_COUNT_DN: assert property (@(posedge clk) disable iff (rst)
    (!clr && xing_pulse && !dir_fwd) |=> current_addr == $past(current_addr) - 1'b1); // R6
  AST_POS_ARRIVED: assert property (@(posedge clk) disable iff (rst)
    pos_mode |-> (demand_addr == current_addr) && !quad_clk); // R10
  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pos_mode && vel_ref_en)); // R9
endmodule

// File: tb/seek_addr_track_bench.sv
module seek_addr_track_bench;
  localparam int W = 9;
  localparam int N = 1 << W;

  logic clk = 0, rst = 1;
  logic fwd_slow = 0, rev_slow = 0, load_pulse = 0, xing_pulse = 0, dir_fwd = 0, quad_clk = 0;
  logic [W-1:0] addr_in = '0;
  logic [W-1:0] demand_addr, current_addr, diff;
  logic diff_zero, move_fwd, vel_ref_en, pos_mode;

  int n_chk = 0, n_fail = 0;
  int m_dem = 0, m_cur = N - 1;
  bit done = 0;

  always #10 clk = ~clk;

  seek_addr_track #(.W(W)) u_seek_addr_track (
    .clk(clk), .rst(rst), .fwd_slow(fwd_slow), .rev_slow(rev_slow),
    .load_pulse(load_pulse), .addr_in(addr_in), .xing_pulse(xing_pulse),
    .dir_fwd(dir_fwd), .quad_clk(quad_clk), .demand_addr(demand_addr),
    .current_addr(current_addr), .diff(diff), .diff_zero(diff_zero),
    .move_fwd(move_fwd), .vel_ref_en(vel_ref_en), .pos_mode(pos_mode));

  always @(posedge clk) begin
    if (rst) begin
      m_dem = 0; m_cur = N - 1;
    end else if (fwd_slow || rev_slow) begin
      m_cur = N - 1;
    end else begin
      if (load_pulse) m_dem = addr_in;
      if (xing_pulse) m_cur = dir_fwd ? (m_cur + 1) % N : (m_cur + N - 1) % N;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit c = fwd_slow || rev_slow;
    int d = (m_dem - m_cur + N) % N;
    chk(c ? "R4 demand" : "R5 R11 demand", demand_addr, m_dem);
    chk(c ? "R2 current" : "R6 R11 current", current_addr, m_cur);
    chk("R7 diff", diff, d);
    chk("R7 zero", diff_zero, d == 0);
    chk("R8 move_fwd", move_fwd, m_dem > m_cur);
    chk(c ? "R3 vel" : "R9 vel", vel_ref_en, !c && d != 0);
    chk(c ? "R3 pos" : "R10 pos", pos_mode, !c && d == 0 && !quad_clk);
  endtask

  task automatic cyc(input bit fs, input bit rs, input bit ld, input int a,
                     input bit xp, input bit dir, input bit q);
    @(negedge clk);
    fwd_slow = fs; rev_slow = rs; load_pulse = ld; addr_in = a[W-1:0];
    xing_pulse = xp; dir_fwd = dir; quad_clk = q;
    #1 compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    load_pulse = 1; addr_in = 9'd77; xing_pulse = 1; dir_fwd = 1;
    @(negedge clk);
    chk("R1 demand reset", demand_addr, 0);
    chk("R1 current reset", current_addr, N - 1);
    load_pulse = 0; xing_pulse = 0;
    rst = 0;
    #1 compare_all();
    cyc(0, 0, 1, 5, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 200, 1, 1, 0);
    cyc(0, 1, 1, 300, 1, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 3, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 10, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 511, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 15);
      cyc(r == 0, r == 1, $urandom_range(0, 7) == 0, $urandom_range(0, N - 1),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule